// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block produces every clock enable that a seven-channel pulse-width modulator needs, all from one master clock. A single free-running counter gives eleven power-of-two enable taps, from one pulse per master cycle down to one pulse every 1024 cycles. Two linear dividers, A and B, each take one of those taps as input and divide it by an 8-bit factor. This gives two more enables, `clk_a` and `clk_b`.

Each of the seven channels has a 4-bit select that picks any one of the thirteen enables. All outputs are single-cycle pulses in the master clock domain, not derived clocks. The generator runs only while the module enable `en` is high. Each divider has its own prescaler-select and divide-factor fields. These fields are loaded through a write strobe, and any load restarts that divider's count.

Top module: `pwm_clkgen`

## Requirements
- R1: While `en` is high, tap n (n = 0..10) pulses in the cycles where the number of enabled cycles since reset is a multiple of 2^n. Tap 0 is therefore high in every enabled cycle.
- R2: While `en` is low, the tap counter holds its value. All of `tap`, `clk_a`, `clk_b` and `ch_tick` stay low.
- R3: Prescaler-select codes 0..10 choose tap 0..10 as the divider's input. Codes 11..15 turn that divider's output off.
- R4: A divide factor of 0 keeps the divider output low. A factor of 1 passes the selected tap through. A factor N from 2 to 255 gives a pulse on every Nth input pulse.
- R5: A write strobe (`wr_a`/`wr_b`) loads that divider's select and factor and clears its input-pulse count. The new ratio applies from the next cycle, so the first output comes on the Nth input pulse after the write.
- R6: The channel select code is a 4-bit field in `ch_sel`. Codes 0..10 choose tap 0..10, code 11 chooses `clk_a` and code 12 chooses `clk_b`. Codes 13..15 give no pulses.
- R7: A synchronous reset (`rst` high) clears the tap counter and both divider counts, and sets both selects and both factors to zero.
- R8: The seven channels select independently. Channel i uses bits `ch_sel[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Module enable |
| wr_a | input | 1 | Load strobe for divider A fields |
| pre_a_in | input | 4 | Divider A prescaler select |
| div_a_in | input | 8 | Divider A factor |
| wr_b | input | 1 | Load strobe for divider B fields |
| pre_b_in | input | 4 | Divider B prescaler select |
| div_b_in | input | 8 | Divider B factor |
| ch_sel | input | 28 | Seven 4-bit channel clock selects |
| tap | output | 11 | Power-of-two enable taps |
| clk_a | output | 1 | Divider A enable |
| clk_b | output | 1 | Divider B enable |
| ch_tick | output | 7 | Per-channel selected enable |

## Verification
A tap counter that is off by even one count moves tap 1 in the very next enabled cycle. A counter that does not hold when `en` is low misplaces every later tap pulse. Either fault therefore shows within a couple of cycles. A divider count that is wrong or not cleared on a write moves the divider pulse only when the next output is due. This can take up to N input pulses, so the bench runs long windows on short taps and also writes in the middle of a divider period. Channel routing faults show in the first cycle in which the wrongly chosen source and the correct one differ.

// File: rtl/pwm_clkgen.sv
module pwm_clkgen #(
  parameter int NCH  = 7,
  parameter int NTAP = 11,
  parameter int DW   = 8,
  parameter int SW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_a,
  input  logic [SW-1:0]     pre_a_in,
  input  logic [DW-1:0]     div_a_in,
  input  logic              wr_b,
  input  logic [SW-1:0]     pre_b_in,
  input  logic [DW-1:0]     div_b_in,
  input  logic [NCH*SW-1:0] ch_sel,
  output logic [NTAP-1:0]   tap,
  output logic              clk_a,
  output logic              clk_b,
  output logic [NCH-1:0]    ch_tick
);
  localparam int CW   = NTAP - 1;
  localparam int SELN = 1 << SW;
  localparam int NCLK = NTAP + 2;

  logic [CW-1:0]   cnt;
  logic [SELN-1:0] tap_x;
  logic [SELN-1:0] clk_x;

  logic          wr   [2];
  logic [SW-1:0] pin  [2];
  logic [DW-1:0] din  [2];
  logic [SW-1:0] pre  [2];
  logic [DW-1:0] div  [2];
  logic [DW-1:0] dcnt [2];
  logic          dsel [2];
  logic          dout [2];

  always_ff @(posedge clk)
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;

  assign tap[0] = en;
  genvar n;
  generate
    for (n = 1; n < NTAP; n++) begin : g_tap
      assign tap[n] = en && (cnt[n-1:0] == '0);
    end
  endgenerate

  assign tap_x = SELN'(tap);

  assign wr[0] = wr_a; assign pin[0] = pre_a_in; assign din[0] = div_a_in;
  assign wr[1] = wr_b; assign pin[1] = pre_b_in; assign din[1] = div_b_in;

  genvar d;
  generate
    for (d = 0; d < 2; d++) begin : g_div
      logic last;
      assign dsel[d] = (32'(pre[d]) < NTAP) && tap_x[pre[d]];
      assign last    = (dcnt[d] == div[d] - 1'b1);
      assign dout[d] = dsel[d] && (div[d] != '0) && last;

      always_ff @(posedge clk)
        if (rst) begin
          pre[d]  <= '0;
          div[d]  <= '0;
          dcnt[d] <= '0;
        end else if (wr[d]) begin
          pre[d]  <= pin[d];
          div[d]  <= din[d];
          dcnt[d] <= '0;
        end else if (dsel[d] && div[d] != '0) begin
          dcnt[d] <= last ? '0 : dcnt[d] + 1'b1;
        end
    end
  endgenerate

  assign clk_a = dout[0];
  assign clk_b = dout[1];
  assign clk_x = SELN'({clk_b, clk_a, tap});

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign ch_tick[c] = (32'(ch_sel[c*SW +: SW]) < NCLK) && clk_x[ch_sel[c*SW +: SW]];
    end
  endgenerate
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk #(
  parameter int NCH  = 7,
  parameter int NTAP = 11,
  parameter int DW   = 8,
  parameter int SW   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [NTAP-1:0]   tap,
  input logic              clk_a,
  input logic              clk_b,
  input logic [NCH-1:0]    ch_tick,
  input logic [NTAP-2:0]   cnt,
  input logic [SW-1:0]     pre_a,
  input logic [DW-1:0]     div_a,
  input logic [DW-1:0]     div_b
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !en |-> (tap == '0 && !clk_a && !clk_b && ch_tick == '0));

  p_halt_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == $past(cnt));

  p_taps_nested_r1: assert property (@(posedge clk) disable iff (rst)
    (tap[NTAP-1:1] & ~tap[NTAP-2:0]) == '0);

  p_zero_factor_off_r4: assert property (@(posedge clk) disable iff (rst)
    div_a == '0 |-> !clk_a);

  p_reserved_pre_off_r3: assert property (@(posedge clk) disable iff (rst)
    32'(pre_a) >= NTAP |-> !clk_a);

  p_div_needs_tap_r4: assert property (@(posedge clk) disable iff (rst)
    (clk_a || clk_b) |-> tap[0]);

  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (cnt == '0 && div_a == '0 && div_b == '0 && pre_a == '0));
endmodule

bind pwm_clkgen pwm_clkgen_chk #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tap(tap), .clk_a(clk_a), .clk_b(clk_b),
  .ch_tick(ch_tick), .cnt(cnt), .pre_a(pre[0]), .div_a(div[0]), .div_b(div[1])
);

// File: tb/pwm_clkgen_test.sv
module pwm_clkgen_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        en = 0;
  logic        wr_a = 0, wr_b = 0;
  logic [3:0]  pre_a_in = 0, pre_b_in = 0;
  logic [7:0]  div_a_in = 0, div_b_in = 0;
  logic [27:0] ch_sel = 0;
  logic [10:0] tap;
  logic        clk_a, clk_b;
  logic [6:0]  ch_tick;

  int checks = 0, errors = 0;

  pwm_clkgen uut (
    .clk(clk), .rst(rst), .en(en), .wr_a(wr_a), .pre_a_in(pre_a_in), .div_a_in(div_a_in),
    .wr_b(wr_b), .pre_b_in(pre_b_in), .div_b_in(div_b_in), .ch_sel(ch_sel),
    .tap(tap), .clk_a(clk_a), .clk_b(clk_b), .ch_tick(ch_tick)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  longint t;
  int m_pre [2];
  int m_div [2];
  int m_pc  [2];

  function automatic bit exp_tap(int n);
    return en && ((t % (longint'(1) << n)) == 0);
  endfunction

  function automatic bit exp_div(int d);
    bit s;
    s = (m_pre[d] < 11) ? exp_tap(m_pre[d]) : 1'b0;
    return s && m_div[d] != 0 && ((m_pc[d] + 1) % m_div[d]) == 0;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      logic [10:0] et;
      logic        ea, eb;
      logic [6:0]  ec;
      logic [12:0] all;
      for (int n = 0; n < 11; n++) et[n] = exp_tap(n);
      ea = exp_div(0);
      eb = exp_div(1);
      all = {eb, ea, et};
      for (int i = 0; i < 7; i++) begin
        int s;
        s = int'(ch_sel[i*4 +: 4]);
        ec[i] = (s < 13) ? all[s] : 1'b0;
      end
      checks++;
      if (tap !== et) begin
        errors++;
        $display("FAIL R1/R2 tap: actual %b expected %b at t=%0d", tap, et, t);
      end
      checks++;
      if (clk_a !== ea) begin
        errors++;
        $display("FAIL R3/R4/R5 clk_a: actual %b expected %b", clk_a, ea);
      end
      checks++;
      if (clk_b !== eb) begin
        errors++;
        $display("FAIL R3/R4/R5 clk_b: actual %b expected %b", clk_b, eb);
      end
      checks++;
      if (ch_tick !== ec) begin
        errors++;
        $display("FAIL R6/R8 ch_tick: actual %b expected %b", ch_tick, ec);
      end
      // advance model to the coming edge
      for (int d = 0; d < 2; d++) begin
        bit s;
        s = (m_pre[d] < 11) ? exp_tap(m_pre[d]) : 1'b0;
        if ((d == 0 && wr_a) || (d == 1 && wr_b)) begin
          m_pre[d] = (d == 0) ? int'(pre_a_in) : int'(pre_b_in);
          m_div[d] = (d == 0) ? int'(div_a_in) : int'(div_b_in);
          m_pc[d]  = 0;
        end else if (s && m_div[d] != 0) begin
          m_pc[d] = (m_pc[d] + 1) % m_div[d];
        end
      end
      if (en) t++;
    end else begin
      t = 0;
      for (int d = 0; d < 2; d++) begin m_pre[d] = 0; m_div[d] = 0; m_pc[d] = 0; end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_a(int p, int dv);
    pre_a_in = 4'(p); div_a_in = 8'(dv); wr_a = 1;
    cyc(1);
    wr_a = 0;
  endtask

  task automatic set_b(int p, int dv);
    pre_b_in = 4'(p); div_b_in = 8'(dv); wr_b = 1;
    cyc(1);
    wr_b = 0;
  endtask

  task automatic set_ch(int s0, int s1, int s2, int s3, int s4, int s5, int s6);
    ch_sel = {4'(s6), 4'(s5), 4'(s4), 4'(s3), 4'(s2), 4'(s1), 4'(s0)};
  endtask

  initial begin
    cyc(3);
    rst = 0;
    // R7: reset state with enable low, all quiet
    cyc(4);
    checks++;
    if (tap !== 0 || clk_a !== 0 || clk_b !== 0) begin
      errors++;
      $display("FAIL R7 reset state: actual %b/%b/%b expected 0", tap, clk_a, clk_b);
    end
    // R1, R6, R8: taps and mixed channel selects
    set_ch(0, 3, 10, 11, 12, 13, 15);
    en = 1;
    cyc(2100);
    // R4 factor 1 pass-through, factor 3 on tap 2
    set_a(1, 1);
    set_b(2, 3);
    cyc(600);
    // R3 reserved select, R4 zero factor
    set_a(11, 5);
    set_b(4, 0);
    cyc(300);
    // R2 enable low, write while idle
    en = 0;
    set_a(1, 2);
    cyc(50);
    en = 1;
    set_b(0, 7);
    cyc(40);
    // R5 rewrite divider mid-period
    set_b(0, 7);
    cyc(3);
    set_b(1, 5);
    set_ch(11, 12, 1, 2, 14, 11, 12);
    cyc(200);
    // R4 largest factor
    set_a(0, 255);
    set_b(3, 2);
    cyc(800);
    // R7 reset mid-run, then resume
    rst = 1;
    cyc(2);
    rst = 0;
    checks++;
    if (clk_a !== 0 || clk_b !== 0) begin
      errors++;
      $display("FAIL R7 dividers after reset: actual %b/%b expected 0/0", clk_a, clk_b);
    end
    cyc(100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule